// File: doc/BRIEF.md
# Lockable Prescaled Watchdog Timer

This block supervises software by counting upward from the moment reset is released. If the count overflows before software services the block, it requests a system reset and pulls an active-low reset pin. Software services it with a one-cycle strobe. The strobe copies an 8-bit reload value into the upper byte of the 16-bit counter and clears the lower byte and the prescaler phase. A smaller reload value gives a longer interval.

A prescaler divides the clock by 2 or by 128 before it reaches the counter. The interval from a service to the timeout edge is exactly `div * (256 - reload) * 256` clock cycles. Software may switch the watchdog off with a disable strobe, but only until it signals the end of initialisation. That signal locks the watchdog on until the next reset.

After a timeout the reset outputs are held active for a fixed 16 cycles. The block then starts again on its own with the lock cleared. A sticky flag records that the reset came from the watchdog, and only the power-on reset clears it.

Top module: `wdog_guard`

## Requirements
- R1: Reset state. After either reset input is released:
  - `sysResetReq` is 0 and `extResetN` is 1.
  - After a power-on reset, `lastWasWdog` is 0.
  - The counter starts at 0000h and runs with no software action, so with `slowSel`=0 the first timeout edge is 2*65536 cycles after release.
- R2: Prescaler. With `slowSel`=0 the counter advances once every 2 clocks. With `slowSel`=1 it advances once every 128 clocks.
- R3: Service. A service strobe sampled at clock edge P does three things: it loads the counter's upper byte from `reloadVal`, and it clears the lower byte and the prescaler phase. The timeout edge is then P + div*(256-reloadVal)*256 if no further service occurs.
- R4: Reset window. On timeout, `sysResetReq`=1 and `extResetN`=0 for exactly 16 cycles. Service strobes during this window have no effect.
- R5: Restart. When the window ends, the counter reloads from `reloadVal` and the lock is cleared, so the next timeout comes div*(256-reloadVal)*256 cycles after `sysResetReq` falls.
- R6: Disable before lock. A `disableReq` strobe before the lock is set stops the counter, and no timeout occurs.
- R7: Lock. An `initDoneStb` strobe sets a lock that only reset or a timeout restart clears. While locked, `disableReq` is ignored. If `initDoneStb` and `disableReq` arrive in the same cycle, the lock is set and the watchdog stays enabled.
- R8: Service wins. A service sampled in the same cycle as an overflow prevents the reset and restarts the interval.
- R9: Reset-source flag. `lastWasWdog` is set by a timeout. It survives `rstN` and is cleared only by `porN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| porN | input | 1 | Asynchronous active-low power-on reset; also clears the reset-source flag |
| serviceStb | input | 1 | One-cycle service strobe from software |
| disableReq | input | 1 | One-cycle request to stop the watchdog (honoured only before lock) |
| initDoneStb | input | 1 | One-cycle end-of-initialisation strobe; sets the lock |
| slowSel | input | 1 | Prescaler select: 0 = divide by 2, 1 = divide by 128 |
| reloadVal | input | 8 | Value loaded into the counter's upper byte on service and restart |
| sysResetReq | output | 1 | Internal hardware reset request, high during the reset window |
| extResetN | output | 1 | Active-low external reset pin |
| lastWasWdog | output | 1 | Sticky flag: the last reset came from a watchdog timeout |

## Verification
The bench predicts the exact cycle of every timeout edge and checks it against what the design produces. This catches several kinds of error:
- A prescaler that keeps its phase across a service, or a service that leaves the low byte alone, moves the timeout by a few cycles.
- A reload taken into the wrong byte moves it by a large amount.

Further cases each show a distinct symptom:
- A service landing exactly on the overflow cycle must suppress the reset. A design that lets the overflow win shows an unexpected pulse.
- A service during the reset window must not shorten the 16-cycle pulse.
- A disable after lock, or together with the lock strobe, must be ignored. A design that honours it misses a timeout that the bench expects.
- A lock that survives the restart makes a later disable fail, and an extra timeout appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // strobes from the control unit to the count datapath
  typedef struct packed {
    logic load;  // reload upper byte, clear lower byte and prescaler phase
    logic run;   // prescaler and counter may advance this cycle
  } wdCmd_t;

  typedef enum logic {
    WD_WATCH = 1'b0,
    WD_HOLD  = 1'b1
  } wdPhase_e;

endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int REL_W    = 8,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdCmd_t           cmd,
  input  logic             slowSel,
  input  logic [REL_W-1:0] reloadVal,
  output logic             wrapNow
);

  localparam int PH_W  = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int LOW_W = CNT_W - REL_W;
  localparam logic [PH_W-1:0] FAST_LIM = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0] SLOW_LIM = PH_W'(SLOW_DIV - 1);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  phaseLim;
  logic             tick;

  assign phaseLim = slowSel ? SLOW_LIM : FAST_LIM;
  assign tick     = cmd.run && (phase >= phaseLim);
  assign wrapNow  = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      cnt   <= '0;
    end else if (cmd.load) begin
      phase <= '0;
      cnt   <= {reloadVal, {LOW_W{1'b0}}};
    end else if (cmd.run) begin
      if (tick) begin
        phase <= '0;
        cnt   <= cnt + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R3
  load_image_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (cnt[LOW_W-1:0] == '0) && (phase == '0)
                 && (cnt[CNT_W-1:LOW_W] == $past(reloadVal)));

  // R6
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.load) |=> $stable(cnt) && $stable(phase));

  // R2
  upward_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.load && !wrapNow) |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   porN,
  input  logic   serviceStb,
  input  logic   disableReq,
  input  logic   initDoneStb,
  input  logic   wrapNow,
  output wdCmd_t cmd,
  output logic   inHold,
  output logic   lastWasWdog
);

  localparam int HOLD_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  wdPhase_e          state;
  logic [HOLD_W-1:0] holdCnt;
  logic              locked;
  logic              enabled;
  logic              holdDone;
  logic              timeout;
  logic              watching;

  assign watching = (state == WD_WATCH);
  assign holdDone = (state == WD_HOLD) && (holdCnt == HOLD_LAST);
  assign timeout  = watching && enabled && wrapNow && !serviceStb;
  assign cmd.load = (watching && serviceStb) || holdDone;
  assign cmd.run  = watching && enabled;
  assign inHold   = (state == WD_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= WD_WATCH;
      holdCnt <= '0;
      locked  <= 1'b0;
      enabled <= 1'b1;
    end else begin
      case (state)
        WD_WATCH: begin
          if (initDoneStb) begin
            locked <= 1'b1;
          end else if (disableReq && !locked) begin
            enabled <= 1'b0;
          end
          if (timeout) begin
            state   <= WD_HOLD;
            holdCnt <= '0;
          end
        end
        default: begin
          if (holdDone) begin
            state   <= WD_WATCH;
            locked  <= 1'b0;
            enabled <= 1'b1;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lastWasWdog <= 1'b0;
    end else if (timeout && rstN) begin
      lastWasWdog <= 1'b1;
    end
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && watching) |=> locked);

  // R7
  locked_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && enabled && watching) |=> enabled);

  // R8
  service_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (watching && serviceStb) |=> (state == WD_WATCH));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (watching && !enabled) |=> (state == WD_WATCH));

  // R4
  hold_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == WD_HOLD) && (holdCnt != HOLD_LAST)) |=> (state == WD_HOLD));

  // R4
  hold_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inHold) |-> (holdCnt == '0));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    lastWasWdog |=> lastWasWdog);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int REL_W    = 8,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 128,
  parameter int HOLD_CYC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             serviceStb,
  input  logic             disableReq,
  input  logic             initDoneStb,
  input  logic             slowSel,
  input  logic [REL_W-1:0] reloadVal,
  output logic             sysResetReq,
  output logic             extResetN,
  output logic             lastWasWdog
);

  wdCmd_t cmd;
  logic   wrapNow;
  logic   inHold;
  logic   anyRstN;

  assign anyRstN = rstN & porN;

  wdog_count #(
    .CNT_W   (CNT_W),
    .REL_W   (REL_W),
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) countPath (
    .clk      (clk),
    .rstN     (anyRstN),
    .cmd      (cmd),
    .slowSel  (slowSel),
    .reloadVal(reloadVal),
    .wrapNow  (wrapNow)
  );

  wdog_ctrl #(
    .HOLD_CYC(HOLD_CYC)
  ) ctrlUnit (
    .clk        (clk),
    .rstN       (anyRstN),
    .porN       (porN),
    .serviceStb (serviceStb),
    .disableReq (disableReq),
    .initDoneStb(initDoneStb),
    .wrapNow    (wrapNow),
    .cmd        (cmd),
    .inHold     (inHold),
    .lastWasWdog(lastWasWdog)
  );

  assign sysResetReq = inHold;
  assign extResetN   = ~inHold;

endmodule

// File: tb/wdog_guard_test.sv
module wdog_guard_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       porN = 1'b0;
  logic       serviceStb = 1'b0;
  logic       disableReq = 1'b0;
  logic       initDoneStb = 1'b0;
  logic       slowSel = 1'b0;
  logic [7:0] reloadVal = 8'hFF;
  logic       sysResetReq;
  logic       extResetN;
  logic       lastWasWdog;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int riseCnt = 0;
  int widthCnt = 0;
  bit prevReq = 1'b0;
  int expQ[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  wdog_guard uut (
    .clk(clk), .rstN(rstN), .porN(porN), .serviceStb(serviceStb),
    .disableReq(disableReq), .initDoneStb(initDoneStb), .slowSel(slowSel),
    .reloadVal(reloadVal), .sysResetReq(sysResetReq), .extResetN(extResetN),
    .lastWasWdog(lastWasWdog)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected timeout cycle at each rising reset request
  always @(negedge clk) begin
    if (rstN && porN) begin
      if (sysResetReq && !prevReq) begin
        riseCnt++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected timeout", cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          chk(cyc == e, "R3 timeout cycle", cyc, e);
        end
        chk(extResetN == 1'b0, "R4 pin low on timeout", int'(extResetN), 0);
        widthCnt = 1;
      end else if (sysResetReq) begin
        widthCnt++;
      end else if (prevReq) begin
        chk(widthCnt == 16, "R4 reset window length", widthCnt, 16);
        chk(extResetN == 1'b1, "R4 pin released", int'(extResetN), 1);
      end
    end
    prevReq = sysResetReq;
  end

  task automatic doReset(input bit por, output int c0);
    @(negedge clk);
    rstN = 1'b0;
    if (por) porN = 1'b0;
    serviceStb = 1'b0;
    disableReq = 1'b0;
    initDoneStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    porN = 1'b1;
    c0 = cyc;
  endtask

  task automatic svc(input logic [7:0] rel, output int p);
    @(negedge clk);
    reloadVal = rel;
    serviceStb = 1'b1;
    @(negedge clk);
    serviceStb = 1'b0;
    p = cyc;
  endtask

  task automatic strobe(input bit dis, input bit ini);
    @(negedge clk);
    disableReq = dis;
    initDoneStb = ini;
    @(negedge clk);
    disableReq = 1'b0;
    initDoneStb = 1'b0;
  endtask

  task automatic waitWindowEnd(output int f);
    while (!sysResetReq) @(negedge clk);
    while (sysResetReq) @(negedge clk);
    f = cyc;
  endtask

  task automatic quiet(input int n, input string req);
    int r0;
    r0 = riseCnt;
    repeat (n) @(negedge clk);
    chk(riseCnt == r0, req, riseCnt - r0, 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, p, f;

    // R1 power-on state and free run from zero
    doReset(1'b1, c0);
    @(negedge clk);
    chk(sysResetReq == 1'b0, "R1 req low after reset", int'(sysResetReq), 0);
    chk(extResetN == 1'b1, "R1 pin high after reset", int'(extResetN), 1);
    chk(lastWasWdog == 1'b0, "R1 flag clear after power-on", int'(lastWasWdog), 0);
    expQ.push_back(c0 + 2 * 65536);
    waitWindowEnd(f);
    chk(lastWasWdog == 1'b1, "R9 flag set by timeout", int'(lastWasWdog), 1);

    // R5 automatic restart from reload FF
    expQ.push_back(f + 2 * 256);
    waitWindowEnd(f);
    doReset(1'b0, c0);
    @(negedge clk);
    chk(lastWasWdog == 1'b1, "R9 flag survives rstN", int'(lastWasWdog), 1);
    chk(sysResetReq == 1'b0, "R1 req low after rstN", int'(sysResetReq), 0);

    // R3 service interval; R4 service inside the window ignored
    svc(8'hFF, p);
    expQ.push_back(p + 2 * 256);
    while (!sysResetReq) @(negedge clk);
    repeat (5) @(negedge clk);
    svc(8'hFF, f);
    waitWindowEnd(f);
    doReset(1'b0, c0);

    // R8 service on the exact overflow cycle
    svc(8'hFF, p);
    while (cyc != p + 511) @(negedge clk);
    serviceStb = 1'b1;
    @(negedge clk);
    serviceStb = 1'b0;
    chk(sysResetReq == 1'b0, "R8 no reset on coincident service", int'(sysResetReq), 0);
    expQ.push_back(p + 1024);
    waitWindowEnd(f);
    doReset(1'b0, c0);

    // R3 periodic servicing at odd phase keeps it quiet
    svc(8'hFE, p);
    for (int i = 0; i < 3; i++) begin
      repeat (900 + i) @(negedge clk);
      svc(8'hFE, p);
    end
    chk(riseCnt == 2 + 2, "R3 no timeout while serviced", riseCnt, 4);
    expQ.push_back(p + 2 * 512);
    waitWindowEnd(f);
    doReset(1'b0, c0);

    // R2 divide-by-128
    slowSel = 1'b1;
    svc(8'hFF, p);
    expQ.push_back(p + 128 * 256);
    waitWindowEnd(f);
    slowSel = 1'b0;
    doReset(1'b0, c0);

    // R6 disable before lock
    strobe(1'b1, 1'b0);
    svc(8'hFF, p);
    quiet(1500, "R6 disabled watchdog quiet");
    doReset(1'b0, c0);

    // R7 lock then disable ignored
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    svc(8'hFF, p);
    expQ.push_back(p + 512);
    waitWindowEnd(f);
    // R5 lock cleared by restart: disable honoured again
    disableReq = 1'b1;
    @(negedge clk);
    disableReq = 1'b0;
    quiet(1500, "R5 lock cleared after restart");
    doReset(1'b0, c0);

    // R7 lock and disable together: lock wins
    strobe(1'b1, 1'b1);
    svc(8'hFF, p);
    expQ.push_back(p + 512);
    waitWindowEnd(f);
    doReset(1'b0, c0);

    // R9 power-on reset clears the flag
    chk(lastWasWdog == 1'b1, "R9 flag before power-on", int'(lastWasWdog), 1);
    doReset(1'b1, c0);
    @(negedge clk);
    chk(lastWasWdog == 1'b0, "R9 flag cleared by porN", int'(lastWasWdog), 0);
    chk(expQ.size() == 0, "R3 all expected timeouts seen", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule